// File: doc/BRIEF.md
# Online XY Route Command Generator

This block turns a single routing request into an ordered stream of reconfiguration commands. The request names the cell of a freshly placed ring-oscillator macro (the source) and the cell of a fixed routing base point that feeds a frequency counter. The generator first asks for the oscillator macro to be placed, then walks east along double-length horizontal wires, turns south, walks along double-length vertical wires and finally turns into the base point. Each hop becomes one typed junction command that names the cell where the junction sits and the number of configuration frames that junction needs.

Commands leave on a valid/ready stream, one per accepted handshake, and a downstream configuration engine applies them. While the stream drains, the block keeps a running command count and a running time estimate that weights the placement and each junction with parameterised costs. Coordinates are unsigned with x growing eastward and y growing southward, and a path can only be built when the source lies west of and north of the base (equal coordinates allowed); any other request is refused without emitting a command.

Controller states: IDLE (after reset, waiting for a request), PLACE (presenting the placement command), HORIZ (presenting horizontal hops), TURN_DOWN (presenting the south-going corner), VERT (presenting vertical hops), TURN_RIGHT (presenting the corner into the base) and DONE (result held, waiting for the next request). Transitions: IDLE/DONE to PLACE on an accepted valid request, IDLE/DONE to DONE on a refused request; PLACE to HORIZ when x distance remains, else to TURN_DOWN when y distance remains, else to DONE; HORIZ to TURN_DOWN or DONE after its last hop, depending on whether y distance remains; TURN_DOWN to VERT; VERT to TURN_RIGHT after its last hop; TURN_RIGHT to DONE. All command-state transitions happen only on a handshake.

Top module: `route_cmd_gen`

## Requirements
- R1: After reset, cmd_valid, busy and done are low, and cmd_total and time_total are zero.
- R2: A start pulse is accepted only when busy is low (in IDLE or DONE); a start while busy is ignored, and the command stream in flight continues unchanged.
- R3: A request with src_x > base_x or src_y > base_y is refused: one cycle after the start, done and rejected are high, busy is low, no command is ever presented, and cmd_total and time_total are zero.
- R4: The first command of every accepted request is the placement: kind 0, at (src_x, src_y), frame count 22.
- R5: Horizontal hops follow the placement while x distance remains: with remaining distance of 2 or more the command has kind 2 (end tap to next horizontal line) and advances x by 2; with remaining distance 1 it has kind 1 (middle tap to next horizontal line) and advances x by 1. Each hop names the cell before the advance and carries frame count 2.
- R6: When src_y < base_y, the horizontal hops are followed by kind 3 (south-going corner) at (base_x, src_y), then vertical hops (kind 4 advancing y by 2 while 2 or more remain, kind 5 advancing y by 1 when 1 remains), then kind 6 (corner into the base) at (base_x, base_y); all with frame count 2.
- R7: A zero-distance request emits only the placement command; a request with src_y == base_y emits no corner command.
- R8: The command word is {kind[26:24], x[23:16], y[15:8], frames[7:0]}; cmd_valid stays high from the placement until the last command is taken, and the word does not change while cmd_valid is high and cmd_ready is low.
- R9: After the last command is taken, done rises on the next cycle and stays high until the next accepted start; cmd_total then equals the number of commands and time_total equals 880 per placement plus 80 per junction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when busy is low |
| src_x | input | 8 | Oscillator cell x (eastward) |
| src_y | input | 8 | Oscillator cell y (southward) |
| base_x | input | 8 | Base point cell x |
| base_y | input | 8 | Base point cell y |
| busy | output | 1 | A command stream is in progress |
| cmd_valid | output | 1 | Command word is valid |
| cmd_ready | input | 1 | Consumer takes the command this cycle |
| cmd_data | output | 27 | Command word {kind, x, y, frames} |
| done | output | 1 | Last request finished (held) |
| rejected | output | 1 | Last request was refused (held with done) |
| cmd_total | output | 16 | Commands emitted for the last request |
| time_total | output | 32 | Accumulated time estimate for the last request |

## Verification
The hardest situation to reach is a request that arrives while a long stream is stalled under backpressure, because the controller must hold both its word and its walk position while ignoring the new coordinates. The bench gets there by pulsing start with different coordinates a few cycles into a stream while cmd_ready is driven from a random pattern, and it compares every presented word against a queue built from the routing rules. Odd and even distances on both axes, a maximal corner-to-corner walk and both refusal directions cover the hop-length switch, the corner insertion and the refusal path.

// File: rtl/route_gen_pkg.sv
`timescale 1ns/1ps
package route_gen_pkg;

    // Command kinds; the encoding is part of the command word.
    typedef enum logic [2:0] {
        K_PLACE        = 3'd0,
        K_H_MID        = 3'd1,
        K_H_END        = 3'd2,
        K_DOWN_CORNER  = 3'd3,
        K_V_END        = 3'd4,
        K_V_MID        = 3'd5,
        K_RIGHT_CORNER = 3'd6
    } conn_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLACE,
        ST_HORIZ,
        ST_TURN_DOWN,
        ST_VERT,
        ST_TURN_RIGHT,
        ST_DONE
    } gen_state_t;

    localparam int KIND_W = 3;

endpackage

// File: rtl/route_hop_step.sv
`timescale 1ns/1ps
import route_gen_pkg::*;

// Decides the next hop along one axis from the current and target cell.
module route_hop_step #(
    parameter int COORD_W  = 8,
    parameter bit VERTICAL = 1'b0
) (
    input  logic [COORD_W-1:0] cur,
    input  logic [COORD_W-1:0] dst,
    output conn_kind_t         kind,
    output logic [COORD_W-1:0] advance,
    output logic               last
);
    logic [COORD_W-1:0] remain;
    logic               long_hop;

    assign remain   = dst - cur;
    assign long_hop = (remain >= COORD_W'(2));
    assign advance  = long_hop ? COORD_W'(2) : COORD_W'(1);
    assign last     = (remain <= COORD_W'(2));

    generate
        if (VERTICAL) begin : g_vert
            assign kind = long_hop ? K_V_END : K_V_MID;
        end else begin : g_horz
            assign kind = long_hop ? K_H_END : K_H_MID;
        end
    endgenerate
endmodule

// File: rtl/route_cost_acc.sv
`timescale 1ns/1ps
// Running command count and weighted time estimate.
module route_cost_acc #(
    parameter int CNT_W      = 16,
    parameter int TIME_W     = 32,
    parameter int PLACE_COST = 880,
    parameter int HOP_COST   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic              is_place,
    output logic [CNT_W-1:0]  count,
    output logic [TIME_W-1:0] total
);
    logic [TIME_W-1:0] weight;
    assign weight = is_place ? TIME_W'(PLACE_COST) : TIME_W'(HOP_COST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            total <= '0;
        end else if (clear) begin
            count <= '0;
            total <= '0;
        end else if (fire) begin
            count <= count + CNT_W'(1);
            total <= total + weight;
        end
    end
endmodule

// File: rtl/route_cmd_pack.sv
`timescale 1ns/1ps
import route_gen_pkg::*;

// Forms the command word {kind, x, y, frames}.
module route_cmd_pack #(
    parameter int COORD_W      = 8,
    parameter int FRAME_W      = 8,
    parameter int PLACE_FRAMES = 22,
    parameter int HOP_FRAMES   = 2,
    localparam int CMD_W       = KIND_W + 2*COORD_W + FRAME_W
) (
    input  conn_kind_t         kind,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic [CMD_W-1:0]   word
);
    logic [FRAME_W-1:0] frames;
    assign frames = (kind == K_PLACE) ? FRAME_W'(PLACE_FRAMES) : FRAME_W'(HOP_FRAMES);
    assign word   = {kind, x, y, frames};
endmodule

// File: rtl/route_cmd_gen.sv
`timescale 1ns/1ps
import route_gen_pkg::*;

module route_cmd_gen #(
    parameter int COORD_W      = 8,
    parameter int FRAME_W      = 8,
    parameter int CNT_W        = 16,
    parameter int TIME_W       = 32,
    parameter int PLACE_FRAMES = 22,
    parameter int HOP_FRAMES   = 2,
    parameter int PLACE_COST   = 880,
    parameter int HOP_COST     = 80,
    localparam int CMD_W       = KIND_W + 2*COORD_W + FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] base_x,
    input  logic [COORD_W-1:0] base_y,
    output logic               busy,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_data,
    output logic               done,
    output logic               rejected,
    output logic [CNT_W-1:0]   cmd_total,
    output logic [TIME_W-1:0]  time_total
);
    gen_state_t         state_q, state_d;
    logic [COORD_W-1:0] cur_x, cur_y, dst_x, dst_y;
    logic               rejected_q;

    logic               accept, refuse, fire;
    conn_kind_t         h_kind, v_kind, out_kind;
    logic [COORD_W-1:0] h_adv, v_adv;
    logic               h_last, v_last;
    logic               x_left, y_left;

    // Request acceptance and refusal (source must be west/north of base).
    assign accept = start && !busy;
    assign refuse = (src_x > base_x) || (src_y > base_y);
    assign fire   = cmd_valid && cmd_ready;
    assign x_left = (dst_x != cur_x);
    assign y_left = (dst_y != cur_y);

    route_hop_step #(.COORD_W(COORD_W), .VERTICAL(1'b0)) u_hstep (
        .cur(cur_x), .dst(dst_x), .kind(h_kind), .advance(h_adv), .last(h_last)
    );

    route_hop_step #(.COORD_W(COORD_W), .VERTICAL(1'b1)) u_vstep (
        .cur(cur_y), .dst(dst_y), .kind(v_kind), .advance(v_adv), .last(v_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = refuse ? ST_DONE : ST_PLACE;
            end
            ST_PLACE: begin
                if (fire) begin
                    if (x_left)      state_d = ST_HORIZ;
                    else if (y_left) state_d = ST_TURN_DOWN;
                    else             state_d = ST_DONE;
                end
            end
            ST_HORIZ: begin
                if (fire && h_last) state_d = y_left ? ST_TURN_DOWN : ST_DONE;
            end
            ST_TURN_DOWN: begin
                if (fire) state_d = ST_VERT;
            end
            ST_VERT: begin
                if (fire && v_last) state_d = ST_TURN_RIGHT;
            end
            ST_TURN_RIGHT: begin
                if (fire) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk position and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_x      <= '0;
            cur_y      <= '0;
            dst_x      <= '0;
            dst_y      <= '0;
            rejected_q <= 1'b0;
        end else if (accept) begin
            cur_x      <= src_x;
            cur_y      <= src_y;
            dst_x      <= base_x;
            dst_y      <= base_y;
            rejected_q <= refuse;
        end else if (fire && state_q == ST_HORIZ) begin
            cur_x <= cur_x + h_adv;
        end else if (fire && state_q == ST_VERT) begin
            cur_y <= cur_y + v_adv;
        end
    end

    // Output logic
    always_comb begin
        cmd_valid = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        out_kind  = K_PLACE;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: done = 1'b1;
            ST_PLACE: begin
                cmd_valid = 1'b1; busy = 1'b1; out_kind = K_PLACE;
            end
            ST_HORIZ: begin
                cmd_valid = 1'b1; busy = 1'b1; out_kind = h_kind;
            end
            ST_TURN_DOWN: begin
                cmd_valid = 1'b1; busy = 1'b1; out_kind = K_DOWN_CORNER;
            end
            ST_VERT: begin
                cmd_valid = 1'b1; busy = 1'b1; out_kind = v_kind;
            end
            ST_TURN_RIGHT: begin
                cmd_valid = 1'b1; busy = 1'b1; out_kind = K_RIGHT_CORNER;
            end
            default: ;
        endcase
    end

    assign rejected = rejected_q && done;

    route_cmd_pack #(
        .COORD_W(COORD_W), .FRAME_W(FRAME_W),
        .PLACE_FRAMES(PLACE_FRAMES), .HOP_FRAMES(HOP_FRAMES)
    ) u_pack (
        .kind(out_kind), .x(cur_x), .y(cur_y), .word(cmd_data)
    );

    route_cost_acc #(
        .CNT_W(CNT_W), .TIME_W(TIME_W),
        .PLACE_COST(PLACE_COST), .HOP_COST(HOP_COST)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .fire(fire),
        .is_place(state_q == ST_PLACE),
        .count(cmd_total), .total(time_total)
    );
endmodule

// File: rtl/route_cmd_gen_chk.sv
`timescale 1ns/1ps
module route_cmd_gen_chk #(
    parameter int COORD_W      = 8,
    parameter int FRAME_W      = 8,
    parameter int CNT_W        = 16,
    parameter int TIME_W       = 32,
    parameter int PLACE_FRAMES = 22,
    parameter int HOP_FRAMES   = 2,
    localparam int CMD_W       = 3 + 2*COORD_W + FRAME_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              done,
    input logic              rejected,
    input logic [CNT_W-1:0]  cmd_total,
    input logic [TIME_W-1:0] time_total
);
    logic [2:0]         kind_f;
    logic [FRAME_W-1:0] frames_f;
    assign kind_f   = cmd_data[CMD_W-1 -: 3];
    assign frames_f = cmd_data[FRAME_W-1:0];

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cmd_ready |=> busy && $stable(cmd_data));

    // R4
    first_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> kind_f == 3'd0 && frames_f == FRAME_W'(PLACE_FRAMES));

    // R5
    hop_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && kind_f != 3'd0 |-> frames_f == FRAME_W'(HOP_FRAMES));

    // R3
    reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> done && !busy && cmd_total == '0 && time_total == '0);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && !busy);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> cmd_total == $past(cmd_total) + CNT_W'(1));
endmodule

bind route_cmd_gen route_cmd_gen_chk #(
    .COORD_W(COORD_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .TIME_W(TIME_W),
    .PLACE_FRAMES(PLACE_FRAMES), .HOP_FRAMES(HOP_FRAMES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .done(done),
    .rejected(rejected), .cmd_total(cmd_total), .time_total(time_total)
);

// File: tb/route_cmd_gen_test.sv
`timescale 1ns/1ps
module route_cmd_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  src_x = '0, src_y = '0, base_x = '0, base_y = '0;
    logic        busy, cmd_valid, done, rejected;
    logic        cmd_ready = 1'b0;
    logic [26:0] cmd_data;
    logic [15:0] cmd_total;
    logic [31:0] time_total;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    route_cmd_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_x(src_x), .src_y(src_y), .base_x(base_x), .base_y(base_y),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .done(done), .rejected(rejected),
        .cmd_total(cmd_total), .time_total(time_total)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [26:0] mk(input int kind, input int x, input int y, input int fr);
        return {kind[2:0], x[7:0], y[7:0], fr[7:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_job(input int sx, input int sy, input int bx, input int by,
                           input int pct, input bit poke);
        logic [26:0] q[$];
        logic [26:0] prev = '0;
        bit prev_hold = 1'b0;
        bit rej;
        int n, x, y, cyc, k;
        string tag;
        rej = (sx > bx) || (sy > by);
        if (!rej) begin
            x = sx; y = sy;
            q.push_back(mk(0, x, y, 22));
            while (bx - x > 0) begin
                if (bx - x >= 2) begin q.push_back(mk(2, x, y, 2)); x += 2; end
                else             begin q.push_back(mk(1, x, y, 2)); x += 1; end
            end
            if (by > y) begin
                q.push_back(mk(3, x, y, 2));
                while (by - y > 0) begin
                    if (by - y >= 2) begin q.push_back(mk(4, x, y, 2)); y += 2; end
                    else             begin q.push_back(mk(5, x, y, 2)); y += 1; end
                end
                q.push_back(mk(6, x, y, 2));
            end
        end
        n = q.size();

        @(negedge clk);
        src_x = sx[7:0]; src_y = sy[7:0]; base_x = bx[7:0]; base_y = by[7:0];
        start = 1'b1; cmd_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        if (rej) begin
            check(done && rejected && !busy && !cmd_valid, "R3", "refused request flags",
                  {done, rejected, busy, cmd_valid}, 4'b1100);
            check(cmd_total == 0 && time_total == 0, "R3", "refused totals",
                  cmd_total, 0);
            repeat (3) @(negedge clk);
            #1;
            check(!cmd_valid && done && rejected, "R3", "no command after refusal",
                  cmd_valid, 0);
            return;
        end
        check(busy && !done, "R2", "busy after accepted start", busy, 1);

        cyc = 0;
        while (!done && cyc < 5000) begin
            cmd_ready = ($urandom_range(0, 99) < pct);
            if (poke) begin
                if (cyc == 3) begin
                    start = 1'b1; src_x = 8'd1; src_y = 8'd1; base_x = 8'd2; base_y = 8'd2;
                end else begin
                    start = 1'b0;
                end
            end
            #1;
            if (cmd_valid) begin
                if (q.size() > 0) begin
                    k = int'(q[0][26:24]);
                    tag = (k == 0) ? "R4" : ((k <= 2) ? "R5" : "R6");
                    if (poke && cyc == 3) tag = "R2";
                    check(cmd_data == q[0], tag, "command word", cmd_data, q[0]);
                end else begin
                    check(1'b0, "R9", "extra command", cmd_data, 0);
                end
                if (prev_hold)
                    check(cmd_data == prev, "R8", "word held under backpressure", cmd_data, prev);
                prev_hold = !cmd_ready;
                prev = cmd_data;
                if (cmd_ready && q.size() > 0) void'(q.pop_front());
            end else begin
                check(1'b0, "R8", "valid dropped mid-stream", 0, 1);
            end
            @(negedge clk);
            #1;
            cyc++;
        end
        start = 1'b0;
        cmd_ready = 1'b0;
        check(done && !rejected, "R9", "done after last command", done, 1);
        check(q.size() == 0, "R9", "all commands delivered", q.size(), 0);
        check(cmd_total == n, "R9", "command count", cmd_total, n);
        check(time_total == 880 + 80*(n-1), "R9", "time estimate", time_total, 880 + 80*(n-1));
        if (sx == bx && sy == by)
            check(cmd_total == 1, "R7", "zero distance emits only placement", cmd_total, 1);
        else if (sy == by)
            check(cmd_total == 1 + (bx - sx + 1)/2, "R7", "no corners on flat path",
                  cmd_total, 1 + (bx - sx + 1)/2);
        repeat (2) @(negedge clk);
        #1;
        check(done && !cmd_valid && cmd_total == n, "R9", "done held while idle", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(!cmd_valid && !busy && !done && cmd_total == 0 && time_total == 0,
              "R1", "reset state", {cmd_valid, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!cmd_valid && !busy && !done, "R1", "idle after reset release",
              {cmd_valid, busy, done}, 0);

        run_job(10, 20, 10, 20, 100, 1'b0);   // R7 zero distance
        run_job(3, 5, 10, 5, 60, 1'b0);       // R5 odd flat walk
        run_job(4, 4, 4, 9, 70, 1'b0);        // R6 vertical only
        run_job(0, 0, 9, 6, 50, 1'b1);        // R2 start while busy
        run_job(12, 3, 10, 5, 100, 1'b0);     // R3 east of base
        run_job(3, 8, 10, 5, 100, 1'b0);      // R3 south of base
        run_job(200, 7, 201, 8, 40, 1'b0);    // R5/R6 single-cell hops
        run_job(2, 2, 8, 10, 30, 1'b1);       // even distances
        run_job(0, 0, 255, 255, 80, 1'b0);    // longest walk

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule